// File: doc/BRIEF.md
# Critical-Word-First Line Fill Sequencer

This block sits between a cache-side requester and a 128-bit memory port. A requester hands it one operation at a time: a full-line read (line fill), a full-line write (eviction), or a narrow single-beat read or write. The block turns each operation into exactly one command on the memory port. The data then moves with no per-beat address. A line is four 128-bit beats (64 bytes). Line beats run in wrap order. The first beat is the one that holds the requested word, selected by address bits [5:4]. Later beats wrap around the line boundary.

On a line fill the block passes each memory beat back to the requester. Each beat is tagged with its position in the line, and the fourth beat is flagged as last. On a write the block takes data beats from the requester, tells it which line position each beat fills, and drives them to memory. A line write enables every byte lane. A narrow write enables only the lanes that the size and the low address bits select.

All data paths are valid/ready streams. A beat moves on a clock edge where both valid and ready are high. The block adds no buffering: during the data phase, the ready going upstream is the ready coming from downstream, and the valid going downstream is the valid coming from upstream. A source that raises valid must keep it and its data steady until the beat is taken. The request port accepts a new operation only when the previous one is fully finished.

Top module: `cwf_line_seq`

## Requirements
- R1: During and straight after reset, req_ready is 1, and mem_cmd_valid, rd_valid and mem_wvalid are 0.
- R2: Each accepted request produces exactly one command. For a line operation, mem_cmd_addr is the request address with bits [3:0] cleared, mem_cmd_line is 1 and mem_cmd_size is 4. For a narrow operation, mem_cmd_addr is the full request address. While the command waits for mem_cmd_ready, it holds its value.
- R3: req_ready stays 0 from the edge that accepts a request until the edge that moves the operation's final data beat.
- R4: A line read moves four beats. Beat n carries rd_idx = (addr[5:4] + n) mod 4, and rd_data equals the memory data of that beat.
- R5: rd_last is 1 only on the fourth beat of a line read and on the single beat of a narrow read.
- R6: A line write moves four beats in the same wrap order, reported on wr_idx. Each beat has mem_wstrb = all 16 ones, whatever req_size holds. mem_wlast is 1 on the fourth beat only.
- R7: A narrow write moves one beat, with mem_wlast = 1 and wr_idx = addr[5:4]. Size codes 0 to 4 mean 1, 2, 4, 8 and 16 bytes, and codes 5 to 7 mean 16 bytes. mem_wstrb enables that many consecutive lanes, starting at addr[3:0] rounded down to a multiple of the byte count.
- R8: During the data phase, mem_rready equals rd_ready on a read and wr_ready equals mem_wready on a write. Outside the data phase both are 0.
- R9: No data beat is offered or accepted on the memory port before the command has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request taken (block idle) |
| req_addr | input | 32 | Byte address of the requested word |
| req_write | input | 1 | 1 = write, 0 = read |
| req_line | input | 1 | 1 = full line, 0 = narrow single beat |
| req_size | input | 3 | Narrow size code, log2 of bytes |
| wr_valid | input | 1 | Write beat offered by requester |
| wr_ready | output | 1 | Write beat taken |
| wr_data | input | 128 | Write beat data |
| wr_idx | output | 2 | Line position the current write beat fills |
| rd_valid | output | 1 | Read beat offered to requester |
| rd_ready | input | 1 | Requester takes read beat |
| rd_data | output | 128 | Read beat data |
| rd_idx | output | 2 | Line position of the read beat |
| rd_last | output | 1 | Final beat of the operation |
| mem_cmd_valid | output | 1 | Command offered to memory |
| mem_cmd_ready | input | 1 | Memory takes command |
| mem_cmd_addr | output | 32 | Command address |
| mem_cmd_write | output | 1 | Command direction |
| mem_cmd_line | output | 1 | 1 = four-beat line, 0 = one beat |
| mem_cmd_size | output | 3 | Size code of each beat |
| mem_wvalid | output | 1 | Write beat offered to memory |
| mem_wready | input | 1 | Memory takes write beat |
| mem_wdata | output | 128 | Write beat data |
| mem_wstrb | output | 16 | Byte lane enables |
| mem_wlast | output | 1 | Final write beat |
| mem_rvalid | input | 1 | Memory offers read beat |
| mem_rready | output | 1 | Read beat taken from memory |
| mem_rdata | input | 128 | Memory read data |

## Verification
The assertions assume that both the requester and the memory behave as streams: a raised valid stays high, with steady data, until it is taken. They also assume memory returns exactly as many read beats as the command asks for, and in wrap order. The bench's memory responder and requester meet these assumptions. Each holds a beat until the handshake is seen, and only then draws a new random valid, so stalls come from random gaps without breaking the rules. The responder derives its beat count and start position only from the accepted command.

// File: rtl/cwf_pkg.sv
package cwf_pkg;

  localparam int SIZE_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_DATA = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic              write;
    logic              line;
    logic [SIZE_W-1:0] size;
  } op_attr_t;

endpackage

// File: rtl/cwf_ctrl.sv
module cwf_ctrl
  import cwf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 4,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  op_attr_t          req_attr,
  output logic              req_ready,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [ADDR_W-1:0] cmd_addr,
  output op_attr_t          op,
  output logic [OFS_W-1:0]  op_ofs,
  output logic [IDX_W-1:0]  start_idx,
  output logic              in_data,
  input  logic              beat_done
);

  seq_state_e        state;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      addr_q <= '0;
      op     <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          addr_q <= req_addr;
          op     <= req_attr;
          state  <= ST_CMD;
        end
        ST_CMD:  if (cmd_ready) state <= ST_DATA;
        ST_DATA: if (beat_done) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign cmd_valid = (state == ST_CMD);
  assign in_data   = (state == ST_DATA);
  assign cmd_addr  = op.line ? {addr_q[ADDR_W-1:OFS_W], {OFS_W{1'b0}}} : addr_q;
  assign op_ofs    = addr_q[OFS_W-1:0];
  assign start_idx = addr_q[OFS_W+IDX_W-1:OFS_W];

  // a stalled command keeps its address and kind
  assert_cmd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(op));

  // a command only appears after a request handshake
  assert_cmd_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) |-> $past(req_valid && req_ready));

  // no new request while a command or data phase is open
  assert_busy_blocks_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid || in_data) |-> !req_ready);

endmodule

// File: rtl/cwf_wrap_cnt.sv
module cwf_wrap_cnt #(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             line,
  input  logic [IDX_W-1:0] start_idx,
  output logic [IDX_W-1:0] idx,
  output logic             last
);

  localparam int               LINE_BEATS = 1 << IDX_W;
  localparam logic [IDX_W-1:0] LAST_N     = IDX_W'(LINE_BEATS - 1);

  logic [IDX_W-1:0] n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     n_q <= '0;
    else if (step)  n_q <= last ? '0 : n_q + 1'b1;
  end

  // modulo wrap comes from the natural overflow of the index width
  assign idx  = start_idx + n_q;
  assign last = line ? (n_q == LAST_N) : 1'b1;

  assert_wrap_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step && !last |=> idx == $past(idx) + 1'b1);

  assert_wrap_rearm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step && last |=> idx == start_idx);

endmodule

// File: rtl/cwf_lane_mask.sv
module cwf_lane_mask
  import cwf_pkg::*;
#(
  parameter int OFS_W = 4
) (
  input  logic              line,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [SIZE_W-1:0] size,
  output logic [(1<<OFS_W)-1:0] strb
);

  localparam int LANES = 1 << OFS_W;
  localparam int CW    = OFS_W + 2;

  logic [SIZE_W-1:0] eff_sz;
  logic [CW-1:0]     nbytes;
  logic [CW-1:0]     lo;
  logic [CW-1:0]     hi;

  always_comb begin
    eff_sz = (size > SIZE_W'(OFS_W)) ? SIZE_W'(OFS_W) : size;
    nbytes = CW'(1) << eff_sz;
    lo     = {2'b00, ofs} & ~(nbytes - 1'b1);
    hi     = lo + nbytes;
  end

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    localparam logic [CW-1:0] LANE = CW'(b);
    assign strb[b] = line || ((LANE >= lo) && (LANE < hi));
  end

endmodule

// File: rtl/cwf_line_seq.sv
module cwf_line_seq
  import cwf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BEAT_BYTES = 16,
  parameter int IDX_W      = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic                    req_write,
  input  logic                    req_line,
  input  logic [2:0]              req_size,
  input  logic                    wr_valid,
  output logic                    wr_ready,
  input  logic [BEAT_BYTES*8-1:0] wr_data,
  output logic [IDX_W-1:0]        wr_idx,
  output logic                    rd_valid,
  input  logic                    rd_ready,
  output logic [BEAT_BYTES*8-1:0] rd_data,
  output logic [IDX_W-1:0]        rd_idx,
  output logic                    rd_last,
  output logic                    mem_cmd_valid,
  input  logic                    mem_cmd_ready,
  output logic [ADDR_W-1:0]       mem_cmd_addr,
  output logic                    mem_cmd_write,
  output logic                    mem_cmd_line,
  output logic [2:0]              mem_cmd_size,
  output logic                    mem_wvalid,
  input  logic                    mem_wready,
  output logic [BEAT_BYTES*8-1:0] mem_wdata,
  output logic [BEAT_BYTES-1:0]   mem_wstrb,
  output logic                    mem_wlast,
  input  logic                    mem_rvalid,
  output logic                    mem_rready,
  input  logic [BEAT_BYTES*8-1:0] mem_rdata
);

  localparam int OFS_W = $clog2(BEAT_BYTES);

  op_attr_t         req_attr;
  op_attr_t         op;
  logic [OFS_W-1:0] op_ofs;
  logic [IDX_W-1:0] start_idx;
  logic [IDX_W-1:0] idx;
  logic             in_data;
  logic             cnt_last;
  logic             step;
  logic             beat_done;
  logic             rd_mode;
  logic             wr_mode;

  assign req_attr = '{write: req_write, line: req_line, size: req_size};

  cwf_ctrl #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_attr  (req_attr),
    .req_ready (req_ready),
    .cmd_valid (mem_cmd_valid),
    .cmd_ready (mem_cmd_ready),
    .cmd_addr  (mem_cmd_addr),
    .op        (op),
    .op_ofs    (op_ofs),
    .start_idx (start_idx),
    .in_data   (in_data),
    .beat_done (beat_done)
  );

  cwf_wrap_cnt #(.IDX_W(IDX_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .line      (op.line),
    .start_idx (start_idx),
    .idx       (idx),
    .last      (cnt_last)
  );

  cwf_lane_mask #(.OFS_W(OFS_W)) u_mask (
    .line (op.line),
    .ofs  (op_ofs),
    .size (op.size),
    .strb (mem_wstrb)
  );

  assign mem_cmd_write = op.write;
  assign mem_cmd_line  = op.line;
  assign mem_cmd_size  = op.line ? SIZE_W'(OFS_W) : op.size;

  assign rd_mode = in_data && !op.write;
  assign wr_mode = in_data &&  op.write;

  // read path: memory beats relayed straight through, tagged in wrap order
  assign rd_valid   = rd_mode && mem_rvalid;
  assign mem_rready = rd_mode && rd_ready;
  assign rd_data    = mem_rdata;
  assign rd_idx     = idx;
  assign rd_last    = rd_valid && cnt_last;

  // write path: requester beats driven to memory with lane enables
  assign mem_wvalid = wr_mode && wr_valid;
  assign wr_ready   = wr_mode && mem_wready;
  assign mem_wdata  = wr_data;
  assign wr_idx     = idx;
  assign mem_wlast  = mem_wvalid && cnt_last;

  assign step      = (rd_valid && rd_ready) || (mem_wvalid && mem_wready);
  assign beat_done = step && cnt_last;

  assert_no_early_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wvalid || mem_rready) |-> !mem_cmd_valid);

  assert_line_full_strb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wvalid && mem_cmd_line |-> (&mem_wstrb));

  assert_narrow_pow2_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wvalid |-> ($countones(mem_wstrb) != 0) &&
      (($countones(mem_wstrb) & ($countones(mem_wstrb) - 1)) == 0));

  assert_wlast_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wvalid && mem_wready && mem_wlast |=> !mem_wvalid && req_ready);

  assert_rlast_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready && rd_last |=> !rd_valid && req_ready);

  assert_ready_path_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_data |-> !mem_rready && !wr_ready);

endmodule

// File: tb/tb_cwf_line_seq.sv
`timescale 1ns/1ps
module tb_cwf_line_seq;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid, req_ready, req_write, req_line;
  logic [31:0]  req_addr;
  logic [2:0]   req_size;
  logic         wr_valid, wr_ready;
  logic [127:0] wr_data;
  logic [1:0]   wr_idx;
  logic         rd_valid, rd_ready, rd_last;
  logic [127:0] rd_data;
  logic [1:0]   rd_idx;
  logic         mem_cmd_valid, mem_cmd_ready, mem_cmd_write, mem_cmd_line;
  logic [31:0]  mem_cmd_addr;
  logic [2:0]   mem_cmd_size;
  logic         mem_wvalid, mem_wready, mem_wlast;
  logic [127:0] mem_wdata;
  logic [15:0]  mem_wstrb;
  logic         mem_rvalid, mem_rready;
  logic [127:0] mem_rdata;

  always #2.5 clk = ~clk;

  cwf_line_seq dut (.*);

  int q_chk = 0, q_fail = 0, m_chk = 0, m_fail = 0, wd_fail = 0;

  // expectations published by the requester, read by the responder
  logic [31:0] e_addr, e_caddr;
  logic        e_write, e_line;
  logic [2:0]  e_size;

  function automatic logic [127:0] pat(input logic [31:0] a, input logic [1:0] i, input bit w);
    return {4{a[31:6], i, w, 3'b101}};
  endfunction

  function automatic logic [15:0] exp_mask(input bit ln, input logic [31:0] a, input logic [2:0] s);
    int es, nb, off;
    if (ln) return 16'hFFFF;
    es  = (s > 3'd4) ? 4 : int'(s);
    nb  = 1 << es;
    off = int'(a[3:0]) & ~(nb - 1);
    return 16'(((32'd1 << nb) - 1) << off);
  endfunction

  task automatic chk_q(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    q_chk++;
    if (!ok) begin q_fail++; $display("FAIL %s actual=%h expected=%h", tag, act, exp); end
  endtask

  task automatic chk_m(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    m_chk++;
    if (!ok) begin m_fail++; $display("FAIL %s actual=%h expected=%h", tag, act, exp); end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", q_chk + m_chk + wd_fail, q_fail + m_fail + wd_fail);
    $finish;
  endtask

  // requester: one operation, then its data beats
  task automatic run_op(input logic [31:0] a, input bit w, input bit ln, input logic [2:0] s);
    int  nb, k;
    bit  busy_bad, took;
    logic [1:0] ix;
    e_addr = a; e_write = w; e_line = ln; e_size = s;
    e_caddr = ln ? {a[31:4], 4'h0} : a;
    @(posedge clk); #1;
    req_valid = 1'b1; req_addr = a; req_write = w; req_line = ln; req_size = s;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0; req_addr = $urandom; req_size = 3'($urandom);
    nb = ln ? 4 : 1; k = 0; busy_bad = 0; took = 0;
    wr_valid = 1'b0;
    while (k < nb) begin
      ix = 2'(a[5:4] + 2'(k));
      if (!w) rd_ready = ($urandom % 3) != 0;
      else if (!wr_valid || took) begin
        wr_valid = ($urandom % 3) != 0;
        wr_data  = pat(a, ix, 1'b1);
        took = 0;
      end
      @(negedge clk);
      if (req_ready) busy_bad = 1;
      if (!w && rd_valid && rd_ready) begin
        chk_q(rd_idx == ix, "R4 rd_idx", 128'(rd_idx), 128'(ix));
        chk_q(rd_data == pat(a, ix, 1'b0), "R4 rd_data", rd_data, pat(a, ix, 1'b0));
        chk_q(rd_last == (k == nb - 1), "R5 rd_last", 128'(rd_last), 128'(k == nb - 1));
        k++;
      end
      if (w && wr_valid && wr_ready) begin
        chk_q(wr_idx == ix, ln ? "R6 wr_idx" : "R7 wr_idx", 128'(wr_idx), 128'(ix));
        took = 1; k++;
      end
      if (k < nb) begin @(posedge clk); #1; end
    end
    chk_q(!busy_bad, "R3 req_ready low while busy", 128'(busy_bad), 128'(0));
    @(posedge clk); #1;
    rd_ready = 1'b0; wr_valid = 1'b0;
  endtask

  // memory responder
  initial begin
    bit got, early, rtook;
    logic [31:0] c_addr;
    bit c_write, c_line;
    int nb, k;
    logic [1:0] ix;
    mem_cmd_ready = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0; mem_wready = 1'b0;
    @(posedge rst_n);
    forever begin
      got = 0; early = 0;
      while (!got) begin
        @(posedge clk); #1;
        mem_rvalid = 1'b0; mem_wready = 1'b0;
        mem_cmd_ready = ($urandom % 3) != 0;
        @(negedge clk);
        if (mem_wvalid || mem_rready) early = 1;
        if (mem_cmd_valid) begin
          chk_m(mem_cmd_addr == e_caddr, "R2 cmd addr", 128'(mem_cmd_addr), 128'(e_caddr));
          if (mem_cmd_ready) begin
            got = 1; c_addr = mem_cmd_addr; c_write = mem_cmd_write; c_line = mem_cmd_line;
            chk_m(mem_cmd_size == (e_line ? 3'd4 : e_size), "R2 cmd size",
                  128'(mem_cmd_size), 128'(e_line ? 3'd4 : e_size));
          end
        end
      end
      chk_m(!early, "R9 beat before command", 128'(early), 128'(0));
      chk_m(c_line == e_line && c_write == e_write, "R2 cmd kind",
            128'({c_line, c_write}), 128'({e_line, e_write}));
      nb = c_line ? 4 : 1; k = 0; rtook = 0;
      while (k < nb) begin
        @(posedge clk); #1;
        mem_cmd_ready = 1'b0;
        ix = 2'(c_addr[5:4] + 2'(k));
        if (!c_write) begin
          if (!mem_rvalid || rtook) begin
            mem_rvalid = ($urandom % 4) != 0;
            mem_rdata  = pat(c_addr, ix, 1'b0);
            rtook = 0;
          end
        end else mem_wready = ($urandom % 2) != 0;
        @(negedge clk);
        if (!c_write) begin
          chk_m(mem_rready == rd_ready, "R8 read ready path", 128'(mem_rready), 128'(rd_ready));
          if (mem_rvalid && mem_rready) begin rtook = 1; k++; end
        end else begin
          chk_m(wr_ready == mem_wready, "R8 write ready path", 128'(wr_ready), 128'(mem_wready));
          if (mem_wvalid && mem_wready) begin
            chk_m(mem_wdata == pat(e_addr, ix, 1'b1), "R6 write data", mem_wdata, pat(e_addr, ix, 1'b1));
            chk_m(mem_wstrb == exp_mask(e_line, e_addr, e_size), e_line ? "R6 line strobe" : "R7 narrow strobe",
                  128'(mem_wstrb), 128'(exp_mask(e_line, e_addr, e_size)));
            chk_m(mem_wlast == (k == nb - 1), e_line ? "R6 wlast" : "R7 wlast",
                  128'(mem_wlast), 128'(k == nb - 1));
            k++;
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    wd_fail = 1;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_write = 1'b0; req_line = 1'b0;
    req_size = '0; wr_valid = 1'b0; wr_data = '0; rd_ready = 1'b0;
    e_addr = '0; e_caddr = '0; e_write = 1'b0; e_line = 1'b0; e_size = '0;
    repeat (3) @(negedge clk);
    chk_q(req_ready && !mem_cmd_valid && !rd_valid && !mem_wvalid, "R1 in reset",
          128'({req_ready, mem_cmd_valid, rd_valid, mem_wvalid}), 128'(4'b1000));
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    chk_q(req_ready && !mem_cmd_valid && !rd_valid && !mem_wvalid, "R1 after reset",
          128'({req_ready, mem_cmd_valid, rd_valid, mem_wvalid}), 128'(4'b1000));

    // directed: every critical-word position, both directions
    for (int i = 0; i < 4; i++) begin
      run_op({24'h8000_12, 2'b00, 2'(i), 4'h9}, 1'b0, 1'b1, 3'd0);
      run_op({24'h4000_34, 2'b11, 2'(i), 4'h3}, 1'b1, 1'b1, 3'($urandom));
    end
    // directed: every narrow size code, both directions
    for (int s = 0; s < 8; s++) begin
      run_op(32'h1000_0000 | ($urandom & 32'h3F), 1'b1, 1'b0, 3'(s));
      run_op(32'h2000_0040 | ($urandom & 32'h3F), 1'b0, 1'b0, 3'(s));
    end
    run_op(32'h0000_003F, 1'b1, 1'b0, 3'd0);
    run_op(32'hFFFF_FFF0, 1'b1, 1'b0, 3'd4);
    // random mix
    for (int n = 0; n < 200; n++)
      run_op($urandom, 1'($urandom), 1'($urandom), 3'($urandom));
    repeat (4) @(posedge clk);
    summary();
  end

endmodule